// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets synchronous logic use a 128K x 16 asynchronous static RAM. A request carries a valid bit, a write flag, a 17-bit word address, 16 bits of write data and one enable per byte lane. The block turns each accepted request into a fully timed memory cycle. Every strobe phase is a whole number of clocks, computed from the nanosecond limits of the memory and the clock period. When the access is over, the block raises a one-clock completion strobe. For a read, the masked read word is ready at the same moment.

The data bus is split into three signals: an output word, a drive enable for each byte lane, and an input word. The pad buffers sit outside the block. The controller drives a byte lane only during a write, and only for the lanes the request enables. After every read it holds back any write drive until the memory has had time to release the bus. A write always ends on the rising edge of write enable, so the data and address set-up windows are measured from that edge.

Top module: `sram_bridge`

## Requirements
- R1: While reset is held and right after it, chip enable, write enable, output enable and both byte enables are high (inactive), no data lane is driven, `req_ready` is 1 and `rsp_done` is 0.
- R2: In a write, write enable stays low for at least ceil(T_PWE_NS/CLK_NS) consecutive clocks, and chip enable is low for every clock in which write enable is low.
- R3: The address and write data are steady for the whole write strobe, and the strobe lasts at least ceil(T_AW_NS/CLK_NS) and ceil(T_SD_NS/CLK_NS) clocks, so that the address-valid and data set-up windows are met before write enable rises.
- R4: Write enable rises at least one clock before chip enable rises and before any lane drive is removed, so that the write always ends on the rising edge of write enable.
- R5: In a write, chip enable stays low for at least ceil(T_WC_NS/CLK_NS) consecutive clocks.
- R6: The low byte enable (data bits 7:0) follows request enable bit 0, and the high byte enable (data bits 15:8) follows request enable bit 1, during the access. A lane is driven only if it is enabled. A lane whose enable is 0 in a write leaves that byte of memory unchanged.
- R7: A read holds chip enable and output enable low and write enable high for at least ceil(max(T_AA_NS, T_DOE_NS)/CLK_NS) clocks. The bus is sampled on the last of those clocks. A lane whose enable is 0 returns zero in `rsp_rdata`.
- R8: Output enable is low only during a read, and no lane is ever driven while output enable is low.
- R9: After output enable rises, at least ceil(T_HZOE_NS/CLK_NS) clocks pass before any lane drive starts.
- R10: Each accepted request yields exactly one `rsp_done` pulse, one clock long. `req_ready` is low from acceptance until after that pulse. A `req_valid` raised while `req_ready` is low is ignored and never reaches the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_done | output | 1 | One-clock completion strobe |
| rsp_rdata | output | 16 | Read word, disabled lanes zero; valid with `rsp_done` after a read |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_drive | output | 2 | Per-lane output drive enable (bit 0 = bits 7:0) |
| mem_dq_in | input | 16 | Data from the memory pads |

## Verification
The bench builds the block with the fast timing set on a 4 ns clock. This gives a 12-clock write strobe, set by the address-valid window rather than the pulse-width limit, a 2-clock tail, a 14-clock read and a 5-clock turnaround. With these counts, each phase ends within one clock of its limit. A phase cut short by a single clock therefore shows up as garbage read data, a short-window report, or a turnaround that is too close. The read-then-write sequences make the turnaround counter the gating path, and the single-lane and no-lane accesses exercise each lane's masking in both directions.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSTB,
    ST_WTAIL,
    ST_READ,
    ST_DONE
  } seq_state_e;

  function automatic int unsigned clk_count(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // write strobe covers pulse width, data set-up and address-valid windows
  function automatic int unsigned strobe_clks(input int unsigned pwe_ns, input int unsigned sd_ns,
                                              input int unsigned aw_ns, input int unsigned clk_ns);
    return max_of(clk_count(pwe_ns, clk_ns), max_of(clk_count(sd_ns, clk_ns), clk_count(aw_ns, clk_ns)));
  endfunction

  // tail keeps chip enable low after the strobe until the cycle time is met
  function automatic int unsigned tail_clks(input int unsigned wc_ns, input int unsigned strobe,
                                            input int unsigned clk_ns);
    int unsigned wc;
    wc = clk_count(wc_ns, clk_ns);
    return (wc > strobe + 1) ? (wc - strobe) : 1;
  endfunction

  function automatic int unsigned read_clks(input int unsigned aa_ns, input int unsigned doe_ns,
                                            input int unsigned clk_ns);
    return max_of(max_of(clk_count(aa_ns, clk_ns), clk_count(doe_ns, clk_ns)), 1);
  endfunction

  function automatic int unsigned turn_clks(input int unsigned hz_ns, input int unsigned clk_ns);
    return max_of(clk_count(hz_ns, clk_ns), 1);
  endfunction

endpackage

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
  import sram_bridge_pkg::*;
#(
  parameter int unsigned STROBE_CLKS = 12,
  parameter int unsigned TAIL_CLKS   = 2,
  parameter int unsigned READ_CLKS   = 14,
  parameter int unsigned TURN_CLKS   = 5,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned TURN_W      = 3,
  parameter int unsigned MIN_PWE     = 10,
  parameter int unsigned MIN_AW      = 12,
  parameter int unsigned MIN_SD      = 7,
  parameter int unsigned MIN_WC      = 14,
  parameter int unsigned MIN_RD      = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic ph_wstb,
  output logic ph_wtail,
  output logic ph_read,
  output logic capture,
  output logic rsp_done
);

  localparam logic [CNT_W-1:0]  STROBE_LOAD = CNT_W'(STROBE_CLKS - 1);
  localparam logic [CNT_W-1:0]  TAIL_LOAD   = CNT_W'(TAIL_CLKS - 1);
  localparam logic [CNT_W-1:0]  READ_LOAD   = CNT_W'(READ_CLKS - 1);
  localparam logic [TURN_W-1:0] TURN_LOAD   = TURN_W'(TURN_CLKS);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  phase_cnt_q, phase_cnt_d;
  logic [TURN_W-1:0] turn_cnt_q;
  logic              phase_last;
  logic              turn_clear;
  logic              read_end;
  logic              write_busy;

  assign phase_last = (phase_cnt_q == '0);
  assign turn_clear = (turn_cnt_q == '0);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign ph_wstb    = (state_q == ST_WSTB);
  assign ph_wtail   = (state_q == ST_WTAIL);
  assign ph_read    = (state_q == ST_READ);
  assign rsp_done   = (state_q == ST_DONE);
  assign read_end   = ph_read && phase_last;
  assign capture    = read_end;
  assign write_busy = ph_wstb || ph_wtail;

  always_comb begin
    state_d     = state_q;
    phase_cnt_d = phase_last ? '0 : phase_cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_write) begin
            state_d     = ST_READ;
            phase_cnt_d = READ_LOAD;
          end else if (turn_clear) begin
            state_d     = ST_WSTB;
            phase_cnt_d = STROBE_LOAD;
          end else begin
            state_d = ST_TURN;
          end
        end
      end
      ST_TURN: begin
        if (turn_clear) begin
          state_d     = ST_WSTB;
          phase_cnt_d = STROBE_LOAD;
        end
      end
      ST_WSTB: begin
        if (phase_last) begin
          state_d     = ST_WTAIL;
          phase_cnt_d = TAIL_LOAD;
        end
      end
      ST_WTAIL: if (phase_last) state_d = ST_DONE;
      ST_READ:  if (phase_last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_cnt_q <= '0;
      turn_cnt_q  <= '0;
    end else begin
      state_q     <= state_d;
      phase_cnt_q <= phase_cnt_d;
      if (read_end)        turn_cnt_q <= TURN_LOAD;
      else if (!turn_clear) turn_cnt_q <= turn_cnt_q - 1'b1;
    end
  end

  // run-length counters that support the window assertions
  logic [31:0] wstb_run_q, wbusy_run_q, read_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstb_run_q  <= '0;
      wbusy_run_q <= '0;
      read_run_q  <= '0;
    end else begin
      wstb_run_q  <= ph_wstb    ? ((wstb_run_q  != '1) ? wstb_run_q  + 32'd1 : wstb_run_q)  : '0;
      wbusy_run_q <= write_busy ? ((wbusy_run_q != '1) ? wbusy_run_q + 32'd1 : wbusy_run_q) : '0;
      read_run_q  <= ph_read    ? ((read_run_q  != '1) ? read_run_q  + 32'd1 : read_run_q)  : '0;
    end
  end

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_wstb) |-> (wstb_run_q >= MIN_PWE));
  a_r3_address_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_wstb) |-> (wstb_run_q >= MIN_AW) && (wstb_run_q >= MIN_SD));
  a_r5_write_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_busy) |-> (wbusy_run_q >= MIN_WC));
  a_r7_read_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_read) |-> (read_run_q >= MIN_RD));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_bridge_lanes.sv
module sram_bridge_lanes #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              ph_access,
  input  logic              ph_wdrive,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  lane_en_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [LANES-1:0]  mem_dq_drive,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      for (int l = 0; l < LANES; l++) begin
        rdata_q[l*LANE_W +: LANE_W] <= be_q[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
      end
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en_n[g]    = !(ph_access && be_q[g]);
    assign mem_dq_drive[g] = ph_wdrive && be_q[g];

    a_r6_drive_enabled_lane: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drive[g] |-> !lane_en_n[g]);
    a_r7_masked_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !be_q[g]) |=> (rsp_rdata[g*LANE_W +: LANE_W] == '0));
  end

  a_r3_payload_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_wdrive && $past(ph_wdrive)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_NS     = 4,
  parameter int unsigned T_WC_NS    = 55,
  parameter int unsigned T_PWE_NS   = 40,
  parameter int unsigned T_SD_NS    = 25,
  parameter int unsigned T_AW_NS    = 45,
  parameter int unsigned T_AA_NS    = 55,
  parameter int unsigned T_DOE_NS   = 25,
  parameter int unsigned T_HZOE_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [1:0]        mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned LANES       = 2;
  localparam int unsigned STROBE_CLKS = strobe_clks(T_PWE_NS, T_SD_NS, T_AW_NS, CLK_NS);
  localparam int unsigned TAIL_CLKS   = tail_clks(T_WC_NS, STROBE_CLKS, CLK_NS);
  localparam int unsigned READ_CLKS   = read_clks(T_AA_NS, T_DOE_NS, CLK_NS);
  localparam int unsigned TURN_CLKS   = turn_clks(T_HZOE_NS, CLK_NS);
  localparam int unsigned CNT_W       = $clog2(max_of(max_of(STROBE_CLKS, TAIL_CLKS), READ_CLKS) + 1);
  localparam int unsigned TURN_W      = $clog2(TURN_CLKS + 1);
  localparam int unsigned MIN_PWE     = clk_count(T_PWE_NS, CLK_NS);
  localparam int unsigned MIN_AW      = clk_count(T_AW_NS, CLK_NS);
  localparam int unsigned MIN_SD      = clk_count(T_SD_NS, CLK_NS);
  localparam int unsigned MIN_WC      = clk_count(T_WC_NS, CLK_NS);
  localparam int unsigned MIN_RD      = max_of(clk_count(T_AA_NS, CLK_NS), clk_count(T_DOE_NS, CLK_NS));
  localparam int unsigned MIN_TURN    = clk_count(T_HZOE_NS, CLK_NS);

  logic accept;
  logic ph_wstb, ph_wtail, ph_read, capture;
  logic ph_access, ph_wdrive;
  logic [LANES-1:0] lane_en_n;

  sram_bridge_seq #(
    .STROBE_CLKS(STROBE_CLKS), .TAIL_CLKS(TAIL_CLKS), .READ_CLKS(READ_CLKS),
    .TURN_CLKS(TURN_CLKS), .CNT_W(CNT_W), .TURN_W(TURN_W),
    .MIN_PWE(MIN_PWE), .MIN_AW(MIN_AW), .MIN_SD(MIN_SD), .MIN_WC(MIN_WC), .MIN_RD(MIN_RD)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .ph_wstb(ph_wstb), .ph_wtail(ph_wtail),
    .ph_read(ph_read), .capture(capture), .rsp_done(rsp_done)
  );

  assign ph_wdrive = ph_wstb || ph_wtail;
  assign ph_access = ph_wdrive || ph_read;

  sram_bridge_lanes #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) i_lanes (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ph_access(ph_access),
    .ph_wdrive(ph_wdrive), .capture(capture), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .lane_en_n(lane_en_n), .mem_dq_out(mem_dq_out),
    .mem_dq_drive(mem_dq_drive), .rsp_rdata(rsp_rdata)
  );

  assign mem_ce_n = !ph_access;
  assign mem_we_n = !ph_wstb;
  assign mem_oe_n = !ph_read;
  assign mem_lb_n = lane_en_n[0];
  assign mem_ub_n = lane_en_n[1];

  // clocks elapsed since output enable last went high (saturating)
  logic [31:0] oe_high_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            oe_high_run_q <= '1;
    else if (!mem_oe_n)    oe_high_run_q <= '0;
    else if (oe_high_run_q != '1) oe_high_run_q <= oe_high_run_q + 32'd1;
  end

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_drive != '0) |-> mem_oe_n);
  a_r8_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  a_r4_we_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n));
  a_r4_drive_outlasts_we: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && ($past(mem_dq_drive) != '0)) |-> (mem_dq_drive != '0));
  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_dq_drive) == '0 && mem_dq_drive != '0) |-> (oe_high_run_q >= MIN_TURN));

endmodule

// File: tb/test_sram_bridge.sv
module test_sram_bridge;

  localparam int CLK_NS  = 4;
  localparam int WE_MIN  = (45 + CLK_NS - 1) / CLK_NS;  // address-valid window, fast grade
  localparam int CE_MIN  = (55 + CLK_NS - 1) / CLK_NS;  // write cycle
  localparam int AA_CLKS = (55 + CLK_NS - 1) / CLK_NS;  // address to data
  localparam int HZ_MIN  = (20 + CLK_NS - 1) / CLK_NS;  // output float

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic [1:0]  mem_dq_drive;
  logic [15:0] mem_dq_in = 16'hBAD0;

  always #2 clk = ~clk;

  sram_bridge #(.CLK_NS(CLK_NS)) i_sram_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and timing monitor ----------------
  logic [15:0] model_mem [int];
  logic [15:0] shadow    [int];
  bit   prev_we = 1, prev_ce = 1, wr_seen = 0, contention = 0;
  logic [1:0]  prev_drive = '0;
  logic [16:0] rd_addr = '0;
  int   we_low = 0, ce_low = 0, rd_run = 0, oe_high = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] word;
      if (!mem_oe_n && mem_dq_drive != 2'b00) contention = 1;
      // turnaround R9
      if (prev_drive == 2'b00 && mem_dq_drive != 2'b00)
        check(oe_high >= HZ_MIN, "R9", "clocks from OE rise to drive", oe_high, HZ_MIN);
      oe_high = mem_oe_n ? oe_high + 1 : 0;
      // write commit on rising write enable
      if (!prev_we && mem_we_n && !mem_ce_n) begin
        check(we_low >= WE_MIN, "R2/R3", "write strobe clocks", we_low, WE_MIN);
        check(mem_dq_drive == {~mem_ub_n, ~mem_lb_n}, "R6", "lane drive at write end",
              mem_dq_drive, {~mem_ub_n, ~mem_lb_n});
        if (!mem_lb_n || !mem_ub_n)
          check(mem_dq_drive != 2'b00, "R4", "drive held past WE rise", mem_dq_drive, 2'b11);
        word = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
        if (!mem_lb_n && mem_dq_drive[0]) word[7:0]  = mem_dq_out[7:0];
        if (!mem_ub_n && mem_dq_drive[1]) word[15:8] = mem_dq_out[15:8];
        model_mem[int'(mem_addr)] = word;
      end
      we_low = mem_we_n ? 0 : we_low + 1;
      if (!mem_we_n) wr_seen = 1;
      // end of chip-enable period
      if (!prev_ce && mem_ce_n) begin
        check(prev_we, "R4", "WE high before CE rise", {31'd0, prev_we}, 1);
        if (wr_seen) check(ce_low >= CE_MIN, "R5", "write CE-low clocks", ce_low, CE_MIN);
        wr_seen = 0;
      end
      ce_low = mem_ce_n ? 0 : ce_low + 1;
      // read data path
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
        rd_run = (rd_run > 0 && mem_addr == rd_addr) ? rd_run + 1 : 1;
      else
        rd_run = 0;
      rd_addr = mem_addr;
      if (rd_run >= AA_CLKS) begin
        word = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
        mem_dq_in <= {mem_ub_n ? 8'hEE : word[15:8], mem_lb_n ? 8'hEE : word[7:0]};
      end else begin
        mem_dq_in <= 16'hBAD0;
      end
      prev_we    = mem_we_n;
      prev_ce    = mem_ce_n;
      prev_drive = mem_dq_drive;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          is_wr;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t sb_q[$];
  int issued = 0, dones = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      dones++;
      if (sb_q.size() == 0) begin
        check(0, "R10", "done with nothing pending", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (!e.is_wr) check(rsp_rdata == e.data, e.req, "read data", rsp_rdata, e.data);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] be, input string req);
    exp_t e;
    logic [15:0] sh;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    sh = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    e.is_wr = wr; e.req = req;
    if (wr) begin
      if (be[0]) sh[7:0]  = d[7:0];
      if (be[1]) sh[15:8] = d[15:8];
      shadow[int'(a)] = sh;
      e.data = 16'h0;
    end else begin
      e.data = {be[1] ? sh[15:8] : 8'h00, be[0] ? sh[7:0] : 8'h00};
    end
    sb_q.push_back(e);
    issued++;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1",
          "strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    rst_n = 1;
    @(negedge clk);
    check(mem_dq_drive == 2'b00 && req_ready && !rsp_done, "R1", "drive/ready/done after reset",
          {mem_dq_drive, req_ready, rsp_done}, 4'b0010);

    // full word, then single lanes (R6), then masked reads (R7)
    do_req(1, 17'h00010, 16'h1234, 2'b11, "R6");
    do_req(0, 17'h00010, 16'h0,    2'b11, "R7");
    do_req(1, 17'h00010, 16'hABCD, 2'b01, "R6");
    do_req(0, 17'h00010, 16'h0,    2'b11, "R6");
    do_req(1, 17'h00010, 16'h77FF, 2'b10, "R6");
    do_req(0, 17'h00010, 16'h0,    2'b11, "R6");
    do_req(0, 17'h00010, 16'h0,    2'b01, "R7");
    do_req(0, 17'h00010, 16'h0,    2'b10, "R7");
    do_req(0, 17'h00010, 16'h0,    2'b00, "R7");
    do_req(1, 17'h00010, 16'h0000, 2'b00, "R6");
    do_req(0, 17'h00010, 16'h0,    2'b11, "R6");

    // address extremes, read immediately followed by write (R9)
    do_req(1, 17'h1FFFF, 16'hC3A5, 2'b11, "R3");
    do_req(1, 17'h00000, 16'h5A3C, 2'b11, "R3");
    do_req(0, 17'h1FFFF, 16'h0,    2'b11, "R3");
    do_req(1, 17'h00000, 16'h0F0F, 2'b11, "R9");
    do_req(0, 17'h00000, 16'h0,    2'b11, "R9");

    // request raised while busy is ignored (R10)
    do_req(1, 17'h00005, 16'h0505, 2'b11, "R10");
    do_req(0, 17'h00005, 16'h0,    2'b11, "R10");
    @(negedge clk);
    check(!req_ready, "R10", "ready low while busy", {31'd0, req_ready}, 0);
    req_valid = 1; req_write = 1; req_addr = 17'h00005; req_wdata = 16'hFFFF; req_be = 2'b11;
    @(negedge clk);
    req_valid = 0;
    do_req(0, 17'h00005, 16'h0, 2'b11, "R10");

    // walking address patterns
    for (int i = 0; i < 8; i++)
      do_req(1, 17'h1 << (2 * i), {8'(i) ^ 8'h5A, ~8'(i)}, 2'b11, "R7");
    for (int i = 0; i < 8; i++)
      do_req(0, 17'h1 << (2 * i), 16'h0, 2'b11, "R7");

    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(dones == issued, "R10", "done count equals requests", dones, issued);
    check(!contention, "R8", "drive while output enable low", {31'd0, contention}, 0);
    finish_run();
  end

endmodule